// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a 32-bit in-order processor core split into five stages: fetch, decode with register read, execute, memory and write-back. Each clock edge moves every instruction one stage on, so once the pipe is full one instruction completes per cycle. It runs a small load/store integer subset: word load, word store, and the register-to-register operations add, subtract, AND and OR. The core has its own instruction memory and its own data memory. Both are filled through a shared preload port while reset is held. The register file has 32 entries, and entry 0 always reads as zero.

Control is decoded once in the decode stage and travels down the staging registers with the instruction, together with the destination register number. A forwarding unit compares the source registers of the instruction in execute with the destinations of the two older instructions in memory and write-back. It steers the newest matching result into either ALU operand. The core has no hazard detection of its own. Software must place at least one unrelated instruction between a load and the first instruction that reads the loaded register.

Completed register writes appear on a write-back observation port. Two combinational peek ports read any register or data memory word, so final state can be inspected.

Top module: `pipe5_core`

## Requirements
- R1: While `rst_n` is low, and during the first four clock cycles after it rises, `wb_we` stays 0. All staging registers reset to bubbles that write neither a register nor memory, and the fetch address restarts at 0.
- R2: Instructions are fetched from consecutive 32-bit words starting at word 0, one per cycle. The instruction at word k reaches write-back on the k+4th rising edge after reset is released.
- R3: An instruction word with bits [31:26] = 0 is register-to-register. Its sources are in [25:21] (A) and [20:16] (B) and its destination is in [15:11]. Bits [5:0] select the operation: 0x20 is A+B, 0x22 is A−B, 0x24 is A AND B, 0x25 is A OR B.
- R4: Bits [31:26] = 0x23 is a load into register [20:16], and 0x2B stores register [20:16]. The address is register [25:21] plus the sign-extended bits [15:0]. Address bits [MEM_AW+1:2] pick the data word; all other address bits are ignored. A store writes no register.
- R5: Register 0 reads as 0. A write to it is discarded, and a result destined for it is never forwarded.
- R6: When the instruction one stage ahead of execute writes a non-zero register that matches an execute source, its ALU result replaces that operand.
- R7: When the instruction two stages ahead writes a matching non-zero register, its write-back value replaces the operand. For a load this is the loaded word. This applies only if R6 does not already supply that operand, so the newer result wins.
- R8: Every result is still written to the register file, whether or not it was also forwarded.
- R9: A register written back in a cycle is seen by the instruction reading it in decode in that same cycle.
- R10: Any other encoding, including all-zero words and unknown values of bits [5:0], writes no register and no memory.
- R11: Forwarding also applies to the store-data operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| pl_we | input | 1 | Preload write strobe |
| pl_dmem | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| pl_addr | input | MEM_AW | Preload word index |
| pl_wdata | input | 32 | Preload data word |
| wb_we | output | 1 | A non-zero register is written this cycle |
| wb_rd | output | 5 | Register written this cycle |
| wb_data | output | 32 | Value written this cycle |
| peek_reg | input | 5 | Register index to inspect |
| peek_reg_data | output | 32 | Contents of the inspected register |
| peek_mem | input | MEM_AW | Data memory word index to inspect |
| peek_mem_data | output | 32 | Contents of the inspected data word |

## Verification
On every cycle the assertions check the following: no write-back occurs during the reset bubbles, the fetch address steps by four, forwarded operands equal the correct older result with the newer stage winning, and a source of register 0 always yields zero. Whether each bypass produces the architecturally right value can only be shown by the bench's programs, compared against an in-order reference model. The same holds for loads feeding later instructions, stores of forwarded data, the same-cycle register-file bypass and ignored encodings. The bench compares each write-back event against the model and checks its cycle, and it dumps every register and data word at the end.

// File: rtl/pipe5_pkg.sv
// Shared encodings and control types for the five-stage core.
// Assumes the fixed 32-bit instruction format with fields at constant positions.
package pipe5_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_OR  = 2'd3
    } alu_op_e;

    // Operand source picked by the forwarding unit
    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_MEM = 2'd1,
        SRC_WB  = 2'd2
    } opnd_src_e;

    // Control bundle created in decode and carried down the pipe
    typedef struct packed {
        logic    reg_wr;
        logic    mem_wr;
        logic    mem_to_reg;
        logic    use_imm;
        alu_op_e alu_op;
    } ctrl_t;

    localparam ctrl_t CTRL_BUBBLE = '{reg_wr: 1'b0, mem_wr: 1'b0, mem_to_reg: 1'b0,
                                      use_imm: 1'b0, alu_op: ALU_ADD};

endpackage

// File: rtl/pipe5_ctrl.sv
// Instruction decoder: turns one instruction word into the control bundle
// and the destination register number. Unknown encodings become bubbles.
module pipe5_ctrl
    import pipe5_pkg::*;
(
    input  logic [31:0] instr,
    output ctrl_t       ctrl,
    output logic [4:0]  dst
);

    logic [5:0] opc;
    logic [5:0] fn;

    assign opc = instr[31:26];
    assign fn  = instr[5:0];

    // Map opcode and function field to control and destination
    always_comb begin
        ctrl = CTRL_BUBBLE;
        dst  = 5'd0;
        unique case (opc)
            OPC_RTYPE: begin
                dst = instr[15:11];
                unique case (fn)
                    FN_ADD: begin ctrl.reg_wr = 1'b1; ctrl.alu_op = ALU_ADD; end
                    FN_SUB: begin ctrl.reg_wr = 1'b1; ctrl.alu_op = ALU_SUB; end
                    FN_AND: begin ctrl.reg_wr = 1'b1; ctrl.alu_op = ALU_AND; end
                    FN_OR:  begin ctrl.reg_wr = 1'b1; ctrl.alu_op = ALU_OR;  end
                    default: dst = 5'd0;
                endcase
            end
            OPC_LOAD: begin
                ctrl.reg_wr     = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.use_imm    = 1'b1;
                dst             = instr[20:16];
            end
            OPC_STORE: begin
                ctrl.mem_wr  = 1'b1;
                ctrl.use_imm = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pipe5_regfile.sv
// Register file with two decode read ports and one inspection port.
// Entry 0 is constant zero. A same-cycle write is bypassed to the readers,
// so write-back and decode may touch one register in one cycle.
module pipe5_regfile #(
    parameter  int DW   = 32,
    parameter  int NREG = 32,
    localparam int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic [AW-1:0] ra_p,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    output logic [DW-1:0] rd_p,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd
);

    logic [DW-1:0] regs [NREG];

    // Clear all entries on reset, otherwise commit one non-zero write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    function automatic logic [DW-1:0] rd_port(input logic [AW-1:0] ra);
        if (ra == '0)               return '0;
        else if (we && (wa == ra))  return wd;
        else                        return regs[ra];
    endfunction

    // Combinational reads with internal write bypass
    always_comb begin
        rd_a = rd_port(ra_a);
        rd_b = rd_port(ra_b);
        rd_p = rd_port(ra_p);
    end

endmodule

// File: rtl/pipe5_fwd.sv
// Forwarding unit: for each execute operand decides whether it comes from
// the register read, the memory-stage result or the write-back result.
// The memory stage wins when both match; register 0 never matches.
module pipe5_fwd
    import pipe5_pkg::*;
#(
    parameter int NOPND = 2
) (
    input  logic [NOPND-1:0][4:0] src,
    input  logic                  mem_wr_en,
    input  logic [4:0]            mem_dst,
    input  logic                  wb_wr_en,
    input  logic [4:0]            wb_dst,
    output opnd_src_e             sel [NOPND]
);

    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
        logic hit_mem;
        logic hit_wb;
        // Compare this operand against both older destinations
        always_comb begin
            hit_mem = mem_wr_en && (mem_dst != 5'd0) && (mem_dst == src[g]);
            hit_wb  = wb_wr_en  && (wb_dst  != 5'd0) && (wb_dst  == src[g]);
            if (hit_mem)     sel[g] = SRC_MEM;
            else if (hit_wb) sel[g] = SRC_WB;
            else             sel[g] = SRC_RF;
        end
    end

endmodule

// File: rtl/pipe5_alu.sv
// Execute-stage ALU for add, subtract, AND and OR; also forms addresses.
module pipe5_alu
    import pipe5_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_op_e       op,
    output logic [DW-1:0] y
);

    // Select the operation
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end

endmodule

// File: rtl/pipe5_core.sv
// Five-stage in-order core: fetch, decode, execute, memory, write-back.
// Assumes no load is followed directly by an instruction reading its
// destination (no interlock). Memories are preloaded while reset is held.
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter  int MEM_AW = 6,
    localparam int DW     = 32,
    localparam int RAW    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pl_we,
    input  logic              pl_dmem,
    input  logic [MEM_AW-1:0] pl_addr,
    input  logic [DW-1:0]     pl_wdata,
    output logic              wb_we,
    output logic [RAW-1:0]    wb_rd,
    output logic [DW-1:0]     wb_data,
    input  logic [RAW-1:0]    peek_reg,
    output logic [DW-1:0]     peek_reg_data,
    input  logic [MEM_AW-1:0] peek_mem,
    output logic [DW-1:0]     peek_mem_data
);

    localparam int NWORDS = 1 << MEM_AW;

    logic [DW-1:0] imem [NWORDS];
    logic [DW-1:0] dmem [NWORDS];

    // ---------------- fetch ----------------
    logic [DW-1:0] pc;
    logic [DW-1:0] if_instr;

    // Program counter: restart at 0, step one word per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc + 32'd4;
    end

    // Instruction memory preload
    always_ff @(posedge clk) begin
        if (pl_we && !pl_dmem) imem[pl_addr] <= pl_wdata;
    end

    assign if_instr = imem[pc[MEM_AW+1:2]];

    logic [DW-1:0] ifid_instr;

    // IF/ID staging: holds the fetched word, all-zero word is a bubble
    always_ff @(posedge clk) begin
        if (!rst_n) ifid_instr <= '0;
        else        ifid_instr <= if_instr;
    end

    // ---------------- decode ----------------
    ctrl_t          id_ctrl;
    logic [RAW-1:0] id_dst;
    logic [RAW-1:0] id_rs;
    logic [RAW-1:0] id_rt;
    logic [DW-1:0]  id_a;
    logic [DW-1:0]  id_b;
    logic [DW-1:0]  id_imm;

    // Write-back signals, declared here for the register file
    ctrl_t          memwb_ctrl;
    logic [RAW-1:0] memwb_dst;
    logic [DW-1:0]  memwb_alu;
    logic [DW-1:0]  memwb_mdata;
    logic [DW-1:0]  wb_val;

    assign id_rs  = ifid_instr[25:21];
    assign id_rt  = ifid_instr[20:16];
    assign id_imm = {{(DW-16){ifid_instr[15]}}, ifid_instr[15:0]};

    pipe5_ctrl u_ctrl (
        .instr (ifid_instr),
        .ctrl  (id_ctrl),
        .dst   (id_dst)
    );

    pipe5_regfile #(.DW(DW), .NREG(1 << RAW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (id_rs),
        .ra_b  (id_rt),
        .ra_p  (peek_reg),
        .rd_a  (id_a),
        .rd_b  (id_b),
        .rd_p  (peek_reg_data),
        .we    (memwb_ctrl.reg_wr),
        .wa    (memwb_dst),
        .wd    (wb_val)
    );

    ctrl_t          idex_ctrl;
    logic [RAW-1:0] idex_rs;
    logic [RAW-1:0] idex_rt;
    logic [RAW-1:0] idex_dst;
    logic [DW-1:0]  idex_a;
    logic [DW-1:0]  idex_b;
    logic [DW-1:0]  idex_imm;

    // ID/EX staging: control, register numbers and operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idex_ctrl <= CTRL_BUBBLE;
            idex_rs   <= '0;
            idex_rt   <= '0;
            idex_dst  <= '0;
            idex_a    <= '0;
            idex_b    <= '0;
            idex_imm  <= '0;
        end else begin
            idex_ctrl <= id_ctrl;
            idex_rs   <= id_rs;
            idex_rt   <= id_rt;
            idex_dst  <= id_dst;
            idex_a    <= id_a;
            idex_b    <= id_b;
            idex_imm  <= id_imm;
        end
    end

    // ---------------- execute ----------------
    ctrl_t          exmem_ctrl;
    logic [RAW-1:0] exmem_dst;
    logic [DW-1:0]  exmem_alu;
    logic [DW-1:0]  exmem_sdata;

    opnd_src_e      ex_sel [2];
    logic [DW-1:0]  ex_opa;
    logic [DW-1:0]  ex_opb_reg;
    logic [DW-1:0]  ex_alu_b;
    logic [DW-1:0]  ex_alu_y;

    pipe5_fwd #(.NOPND(2)) u_fwd (
        .src       ({idex_rt, idex_rs}),
        .mem_wr_en (exmem_ctrl.reg_wr),
        .mem_dst   (exmem_dst),
        .wb_wr_en  (memwb_ctrl.reg_wr),
        .wb_dst    (memwb_dst),
        .sel       (ex_sel)
    );

    function automatic logic [DW-1:0] pick(input opnd_src_e s, input logic [DW-1:0] rf_v);
        unique case (s)
            SRC_MEM: return exmem_alu;
            SRC_WB:  return wb_val;
            default: return rf_v;
        endcase
    endfunction

    // Operand multiplexers in front of the ALU
    always_comb begin
        ex_opa     = pick(ex_sel[0], idex_a);
        ex_opb_reg = pick(ex_sel[1], idex_b);
        ex_alu_b   = idex_ctrl.use_imm ? idex_imm : ex_opb_reg;
    end

    pipe5_alu #(.DW(DW)) u_alu (
        .a  (ex_opa),
        .b  (ex_alu_b),
        .op (idex_ctrl.alu_op),
        .y  (ex_alu_y)
    );

    // EX/MEM staging: result, store data and remaining control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exmem_ctrl  <= CTRL_BUBBLE;
            exmem_dst   <= '0;
            exmem_alu   <= '0;
            exmem_sdata <= '0;
        end else begin
            exmem_ctrl  <= idex_ctrl;
            exmem_dst   <= idex_dst;
            exmem_alu   <= ex_alu_y;
            exmem_sdata <= ex_opb_reg;
        end
    end

    // ---------------- memory ----------------
    logic [MEM_AW-1:0] dm_idx;
    logic [DW-1:0]     dm_rdata;

    assign dm_idx        = exmem_alu[MEM_AW+1:2];
    assign dm_rdata      = dmem[dm_idx];
    assign peek_mem_data = dmem[peek_mem];

    // Data memory: store from the pipe, else preload
    always_ff @(posedge clk) begin
        if (rst_n && exmem_ctrl.mem_wr) dmem[dm_idx]  <= exmem_sdata;
        else if (pl_we && pl_dmem)      dmem[pl_addr] <= pl_wdata;
    end

    // MEM/WB staging: ALU result and load data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            memwb_ctrl  <= CTRL_BUBBLE;
            memwb_dst   <= '0;
            memwb_alu   <= '0;
            memwb_mdata <= '0;
        end else begin
            memwb_ctrl  <= exmem_ctrl;
            memwb_dst   <= exmem_dst;
            memwb_alu   <= exmem_alu;
            memwb_mdata <= dm_rdata;
        end
    end

    // ---------------- write-back ----------------
    assign wb_val  = memwb_ctrl.mem_to_reg ? memwb_mdata : memwb_alu;
    assign wb_we   = memwb_ctrl.reg_wr && (memwb_dst != '0);
    assign wb_rd   = memwb_dst;
    assign wb_data = wb_val;

    logic unused_bits;
    assign unused_bits = ^{pc[DW-1:MEM_AW+2], pc[1:0], ifid_instr[10:6],
                           memwb_ctrl.mem_wr, memwb_ctrl.use_imm, memwb_ctrl.alu_op};

endmodule

// File: rtl/pipe5_core_chk.sv
// Assertion checker bound to pipe5_core: reset bubbles, fetch stepping,
// forwarding priority and register-0 operands.
module pipe5_core_chk
    import pipe5_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wb_we,
    input logic [31:0] pc,
    input logic [4:0]  idex_rs,
    input logic [4:0]  idex_rt,
    input logic [31:0] ex_opa,
    input logic [31:0] ex_opb_reg,
    input logic        exmem_rw,
    input logic [4:0]  exmem_dst,
    input logic [31:0] exmem_alu,
    input logic        memwb_rw,
    input logic [4:0]  memwb_dst,
    input logic [31:0] wb_val
);

    logic [2:0] since_rst;

    // Count the first cycles after reset release
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst < 3'd4) since_rst <= since_rst + 3'd1;
    end

    // R1
    reset_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 3'd4) |-> !wb_we);

    // R2
    fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pc == $past(pc) + 32'd4));

    // R6
    fwd_mem_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exmem_rw && exmem_dst != 5'd0 && exmem_dst == idex_rs) |-> (ex_opa == exmem_alu));

    // R6
    fwd_mem_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exmem_rw && exmem_dst != 5'd0 && exmem_dst == idex_rt) |-> (ex_opb_reg == exmem_alu));

    // R7
    fwd_wb_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(exmem_rw && exmem_dst == idex_rs) && memwb_rw && memwb_dst != 5'd0
         && memwb_dst == idex_rs) |-> (ex_opa == wb_val));

    // R5
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_rs == 5'd0) |-> (ex_opa == 32'd0));

endmodule

bind pipe5_core pipe5_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wb_we      (wb_we),
    .pc         (pc),
    .idex_rs    (idex_rs),
    .idex_rt    (idex_rt),
    .ex_opa     (ex_opa),
    .ex_opb_reg (ex_opb_reg),
    .exmem_rw   (exmem_ctrl.reg_wr),
    .exmem_dst  (exmem_dst),
    .exmem_alu  (exmem_alu),
    .memwb_rw   (memwb_ctrl.reg_wr),
    .memwb_dst  (memwb_dst),
    .wb_val     (wb_val)
);

// File: tb/pipe5_core_tb.sv
// Bench: runs directed and seeded random programs, compares each write-back
// and the final register and memory state against an in-order model.
module pipe5_core_tb;

    localparam int AW = 6;
    localparam int NW = 1 << AW;

    logic          clk;
    logic          rst_n;
    logic          pl_we;
    logic          pl_dmem;
    logic [AW-1:0] pl_addr;
    logic [31:0]   pl_wdata;
    logic          wb_we;
    logic [4:0]    wb_rd;
    logic [31:0]   wb_data;
    logic [4:0]    peek_reg;
    logic [31:0]   peek_reg_data;
    logic [AW-1:0] peek_mem;
    logic [31:0]   peek_mem_data;

    pipe5_core #(.MEM_AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pl_we(pl_we), .pl_dmem(pl_dmem),
        .pl_addr(pl_addr), .pl_wdata(pl_wdata), .wb_we(wb_we), .wb_rd(wb_rd),
        .wb_data(wb_data), .peek_reg(peek_reg), .peek_reg_data(peek_reg_data),
        .peek_mem(peek_mem), .peek_mem_data(peek_mem_data)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] prog     [NW];
    logic [31:0] mem_init [NW];
    int          nprog;
    logic [31:0] rref [32];
    logic [31:0] mref [NW];
    int          exp_rd  [NW];
    logic [31:0] exp_val [NW];
    int          exp_cyc [NW];
    int          nexp;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_m(input logic [5:0] op, input int rt, input int rs, input int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    // In-order reference model of the requirements (R3, R4, R5, R10)
    task automatic ref_run();
        for (int r = 0; r < 32; r++) rref[r] = '0;
        for (int m = 0; m < NW; m++) mref[m] = mem_init[m];
        nexp = 0;
        for (int i = 0; i < nprog; i++) begin
            logic [31:0] ins, a, b, v, ea;
            int dst;
            bit wr;
            ins = prog[i];
            a   = rref[ins[25:21]];
            b   = rref[ins[20:16]];
            wr  = 0; dst = 0; v = '0;
            ea  = a + {{16{ins[15]}}, ins[15:0]};
            case (ins[31:26])
                6'h00: begin
                    dst = int'(ins[15:11]);
                    case (ins[5:0])
                        6'h20: begin v = a + b; wr = 1; end
                        6'h22: begin v = a - b; wr = 1; end
                        6'h24: begin v = a & b; wr = 1; end
                        6'h25: begin v = a | b; wr = 1; end
                        default: wr = 0;
                    endcase
                end
                6'h23: begin dst = int'(ins[20:16]); v = mref[ea[AW+1:2]]; wr = 1; end
                6'h2B: mref[ea[AW+1:2]] = b;
                default: wr = 0;
            endcase
            if (wr && dst != 0) begin
                rref[dst]     = v;
                exp_rd[nexp]  = dst;
                exp_val[nexp] = v;
                exp_cyc[nexp] = i + 4;
                nexp++;
            end
        end
    endtask

    task automatic run_prog(input string tag);
        int ei;
        ref_run();
        @(negedge clk);
        rst_n = 1'b0;
        pl_we = 1'b1;
        for (int i = 0; i < NW; i++) begin
            pl_dmem = 1'b0; pl_addr = AW'(i); pl_wdata = (i < nprog) ? prog[i] : 32'd0;
            @(negedge clk);
        end
        for (int i = 0; i < NW; i++) begin
            pl_dmem = 1'b1; pl_addr = AW'(i); pl_wdata = mem_init[i];
            @(negedge clk);
        end
        pl_we = 1'b0;
        #1;
        // R1: no write-back while reset is held
        chk(wb_we == 1'b0, "R1", {tag, " write-back during reset"}, 32'(wb_we), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        ei = 0;
        for (int c = 0; c < nprog + 8; c++) begin
            #1;
            if (c < 4)
                chk(wb_we == 1'b0, "R1", {tag, " write-back in reset bubble"}, 32'(wb_we), 32'd0);
            if (wb_we) begin
                if (ei < nexp) begin
                    chk(int'(wb_rd) == exp_rd[ei], "R3/R4", {tag, " write-back register"},
                        32'(wb_rd), 32'(exp_rd[ei]));
                    chk(wb_data == exp_val[ei], "R6/R7", {tag, " write-back value"},
                        wb_data, exp_val[ei]);
                    // R2: completion cycle of instruction k is k+4
                    chk(c == exp_cyc[ei], "R2", {tag, " write-back cycle"}, 32'(c), 32'(exp_cyc[ei]));
                end else begin
                    chk(1'b0, "R10", {tag, " unexpected write-back"}, 32'(wb_rd), 32'd0);
                end
                ei++;
            end
            @(negedge clk);
        end
        chk(ei == nexp, "R2", {tag, " write-back count"}, 32'(ei), 32'(nexp));
        // R8 and R5: final register contents
        for (int r = 0; r < 32; r++) begin
            peek_reg = 5'(r);
            #1;
            chk(peek_reg_data == rref[r], (r == 0) ? "R5" : "R8", {tag, " final register"},
                peek_reg_data, rref[r]);
        end
        // R4, R11: final data memory contents
        for (int m = 0; m < NW; m++) begin
            peek_mem = AW'(m);
            #1;
            chk(peek_mem_data == mref[m], "R4/R11", {tag, " final memory word"},
                peek_mem_data, mref[m]);
        end
    endtask

    task automatic put(input logic [31:0] ins);
        prog[nprog] = ins;
        nprog++;
    endtask

    task automatic fill_mem();
        for (int m = 0; m < NW; m++) mem_init[m] = $urandom();
    endtask

    // Directed program covering each bypass path and the corner cases
    task automatic build_directed();
        nprog = 0;
        fill_mem();
        put(enc_m(6'h23, 1, 0, 0));          // lw r1, 0(r0)
        put(enc_m(6'h23, 3, 0, 4));          // lw r3, 4(r0)
        put(enc_m(6'h23, 5, 0, 8));          // lw r5, 8(r0)
        put(32'd0);
        put(enc_r(6'h22, 2, 1, 3));          // sub r2 = r1 - r3
        put(enc_r(6'h24, 4, 2, 5));          // R6: and r4 = r2 & r5
        put(enc_r(6'h25, 4, 4, 2));          // R6 on A, R7 on B
        put(enc_r(6'h20, 9, 4, 2));          // R7 priority on A, R9 on B
        put(enc_m(6'h2B, 9, 0, 12));         // R11: sw r9, 12(r0)
        put(enc_m(6'h23, 6, 0, 12));         // lw r6, 12(r0)
        put(32'd0);
        put(enc_r(6'h20, 7, 6, 6));          // R7: load data bypass
        put(enc_r(6'h20, 0, 1, 3));          // R5: write to r0
        put(enc_r(6'h20, 8, 0, 0));          // R5: reads zero
        put(enc_r(6'h20, 10, 3, 0));
        put(enc_m(6'h2B, 3, 10, -8));        // R4: forwarded base, negative offset
        put(32'hFFFF_FFFF);                  // R10: unknown opcode
        put(enc_r(6'h21, 12, 1, 3));         // R10: unknown function field
        put(enc_r(6'h20, 13, 12, 1));
        put(enc_m(6'h23, 14, 10, -8));       // R4: load back the store
        put(32'd0);
        put(enc_r(6'h22, 15, 14, 13));
    endtask

    // Random program over a few registers, loads never directly consumed
    task automatic build_random(input int n);
        int last_ld;
        nprog   = 0;
        last_ld = 0;
        fill_mem();
        for (int i = 0; i < n; i++) begin
            int k, rd, rs, rt, imm, this_ld;
            k  = int'($urandom_range(0, 9));
            rd = int'($urandom_range(0, 7));
            rs = int'($urandom_range(0, 7));
            rt = int'($urandom_range(0, 7));
            imm = int'($urandom_range(0, 511)) - 256;
            if (last_ld != 0 && rs == last_ld) rs = 0;
            if (last_ld != 0 && rt == last_ld && k >= 5 && k <= 6) rt = rt;
            else if (last_ld != 0 && rt == last_ld) rt = 0;
            this_ld = 0;
            if (k <= 4) begin
                logic [5:0] fn;
                case ($urandom_range(0, 3))
                    0: fn = 6'h20;
                    1: fn = 6'h22;
                    2: fn = 6'h24;
                    default: fn = 6'h25;
                endcase
                put(enc_r(fn, rd, rs, rt));
            end else if (k <= 6) begin
                put(enc_m(6'h23, rt, rs, imm));
                this_ld = rt;
            end else if (k <= 8) begin
                put(enc_m(6'h2B, rt, rs, imm));
            end else begin
                put(32'd0);
            end
            last_ld = this_ld;
        end
    endtask

    initial begin
        rst_n = 1'b0; pl_we = 1'b0; pl_dmem = 1'b0; pl_addr = '0; pl_wdata = '0;
        peek_reg = '0; peek_mem = '0;
        void'($urandom(32'd2024));
        build_directed();
        run_prog("directed");
        for (int s = 0; s < 3; s++) begin
            build_random(40);
            run_prog("random");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog run did not finish actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule